// File: doc/BRIEF.md
# Backplane Frame Offset Calibration Unit

This block measures how far the frame start of an incoming serial backplane stream lags the reference frame pulse, and then realigns the frame start of each stream by a programmable amount. The host selects a stream and starts a measurement by writing a control register. During a measurement the stream under test carries a marker, which is a high-to-low transition at its frame start. The block counts master-clock cycles from the reference frame pulse to the first such transition. It then stores the count, a completion flag and an overflow flag in that stream's result register. Hardware clears the start bit when the measurement ends.

Each stream has its own offset register. The stream's realigned frame-start strobe fires that many master-clock cycles after the reference frame pulse. A newly written offset waits in a pending register and is copied into use only when a reference frame pulse arrives, so a frame that is already running is never shortened or stretched.

With the defaults there are 24 streams and a bit period of 4 master-clock cycles. A frame lasts 128 cycles. Offsets and measured values saturate at eight bit periods, which is 32 cycles.

Top module: `frame_offset_cal`

## Requirements
- R1: After reset, every register reads zero and no frame-start strobe fires before the first reference frame pulse.
- R2: Writing the control register (address 0) with bit 7 set and a stream number below 24 in bits 4:0 while idle starts a measurement. The control register then reads bit 7 = 1 with the stream number, and that stream's result register reads zero.
- R3: Let the reference frame pulse (fp_n low) be sampled at clock edge k. The measured value is d when the selected stream is first sampled low after being high at edge k+1+d. The result register (address 0x20 + stream) holds the value in bits 5:0, the completion flag in bit 6 and the overflow flag in bit 7.
- R4: The measured value saturates at 32 (eight bit periods). The overflow flag stays 0 when a transition is found after saturation.
- R5: If the next reference frame pulse arrives before any transition, the result reads overflow = 1, completion = 1 and value = 32.
- R6: When a measurement ends, hardware clears control bit 7 and sets the completion flag of the measured stream. Results of other streams are kept.
- R7: A control write is ignored while a measurement is running, and also when its stream number is 24 or above.
- R8: Offset registers (address 0x40 + stream) accept 0 to 32. Larger writes are stored as 32, and a read returns the stored pending value.
- R9: frame_start_out[s] is high for exactly one cycle per frame: the cycle in which the number of cycles since the reference pulse edge equals the offset in use for stream s.
- R10: A written offset is put into use only at the next reference frame pulse. The frame already running keeps the old offset.
- R11: Transitions on streams other than the selected one do not affect the measurement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fp_n | input | 1 | Reference frame pulse, active low for one cycle |
| stream_in | input | 24 | Serial backplane stream inputs |
| wr_en | input | 1 | Host register write strobe |
| wr_addr | input | 7 | Host write address |
| wr_data | input | 8 | Host write data |
| rd_addr | input | 7 | Host read address |
| rd_data | output | 8 | Host read data, combinational from rd_addr |
| frame_start_out | output | 24 | Realigned per-stream frame-start strobes |

## Verification
The assertions check on every cycle that stored values and offsets never exceed the saturation limit, and that an overflow result always carries the limit value. They also check that a finished measurement leaves its completion flag set, that the selected stream cannot change while a measurement runs, and that offsets in use change only on a reference pulse. The exact measured count for a given marker position, the blindness to other streams, and where each realigned strobe lands in the frame can only be shown by the bench's timed scenarios.

// File: rtl/frame_offset_cal_pkg.sv
package frame_offset_cal_pkg;

  // measurement sequencer states
  typedef enum logic [1:0] {
    MS_IDLE = 2'b00,
    MS_ARM  = 2'b01,
    MS_MEAS = 2'b10
  } meas_state_e;

  // register regions, taken from the two top address bits
  localparam logic [1:0] REG_CTRL = 2'b00;
  localparam logic [1:0] REG_RES  = 2'b01;
  localparam logic [1:0] REG_OFS  = 2'b10;

endpackage

// File: rtl/fofc_frame_timer.sv
module fofc_frame_timer #(
  parameter int FRAME_CYC = 128,
  localparam int CNT_W = $clog2(FRAME_CYC)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fp_hit,
  output logic [CNT_W-1:0] cnt
);

  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(FRAME_CYC - 1);

  logic [CNT_W-1:0] cnt_d, cnt_q;
  logic             cnt_en;

  always_comb begin
    cnt_en = fp_hit || (cnt_q != CNT_MAX);
    cnt_d  = fp_hit ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= CNT_MAX;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;

endmodule

// File: rtl/fofc_measure.sv
module fofc_measure
  import frame_offset_cal_pkg::*;
#(
  parameter int NUM_STREAMS = 24,
  parameter int SAT         = 32,
  localparam int VAL_W      = $clog2(SAT + 1),
  localparam int SEL_W      = $clog2(NUM_STREAMS)
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              start_req,
  input  logic [SEL_W-1:0]                  start_sel,
  input  logic                              fp_hit,
  input  logic [NUM_STREAMS-1:0]            streams,
  output logic                              busy,
  output logic [SEL_W-1:0]                  sel,
  output logic [NUM_STREAMS-1:0][VAL_W-1:0] res_val,
  output logic [NUM_STREAMS-1:0]            res_done,
  output logic [NUM_STREAMS-1:0]            res_ovf
);

  localparam logic [VAL_W-1:0] SAT_V = VAL_W'(SAT);

  meas_state_e                       st_d, st_q;
  logic [SEL_W-1:0]                  sel_d, sel_q;
  logic [VAL_W-1:0]                  cnt_d, cnt_q;
  logic [NUM_STREAMS-1:0]            prev_q;
  logic [NUM_STREAMS-1:0][VAL_W-1:0] val_d, val_q;
  logic [NUM_STREAMS-1:0]            done_d, done_q, ovf_d, ovf_q;
  logic                              marker;

  assign marker = prev_q[sel_q] && !streams[sel_q];

  always_comb begin
    st_d   = st_q;
    sel_d  = sel_q;
    cnt_d  = cnt_q;
    val_d  = val_q;
    done_d = done_q;
    ovf_d  = ovf_q;
    unique case (st_q)
      MS_IDLE: begin
        if (start_req && (start_sel < SEL_W'(NUM_STREAMS))) begin
          st_d              = MS_ARM;
          sel_d             = start_sel;
          val_d[start_sel]  = '0;
          done_d[start_sel] = 1'b0;
          ovf_d[start_sel]  = 1'b0;
        end
      end
      MS_ARM: begin
        if (fp_hit) begin
          st_d  = MS_MEAS;
          cnt_d = '0;
        end
      end
      MS_MEAS: begin
        if (marker) begin
          st_d          = MS_IDLE;
          val_d[sel_q]  = cnt_q;
          done_d[sel_q] = 1'b1;
        end else if (fp_hit) begin
          st_d          = MS_IDLE;
          val_d[sel_q]  = SAT_V;
          done_d[sel_q] = 1'b1;
          ovf_d[sel_q]  = 1'b1;
        end else if (cnt_q != SAT_V) begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: st_d = MS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= MS_IDLE;
      sel_q  <= '0;
      cnt_q  <= '0;
      prev_q <= '0;
      val_q  <= '0;
      done_q <= '0;
      ovf_q  <= '0;
    end else begin
      st_q   <= st_d;
      sel_q  <= sel_d;
      cnt_q  <= cnt_d;
      prev_q <= streams;
      val_q  <= val_d;
      done_q <= done_d;
      ovf_q  <= ovf_d;
    end
  end

  assign busy     = (st_q != MS_IDLE);
  assign sel      = sel_q;
  assign res_val  = val_q;
  assign res_done = done_q;
  assign res_ovf  = ovf_q;

endmodule

// File: rtl/fofc_offset_bank.sv
module fofc_offset_bank #(
  parameter int NUM_STREAMS = 24,
  parameter int SAT         = 32,
  parameter int DATA_W      = 8,
  parameter int CNT_W       = 7,
  localparam int VAL_W      = $clog2(SAT + 1),
  localparam int SEL_W      = $clog2(NUM_STREAMS)
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              wr_ofs,
  input  logic [SEL_W-1:0]                  wr_idx,
  input  logic [DATA_W-1:0]                 wr_val,
  input  logic                              fp_hit,
  input  logic [CNT_W-1:0]                  cnt,
  output logic [NUM_STREAMS-1:0][VAL_W-1:0] pend,
  output logic [NUM_STREAMS-1:0][VAL_W-1:0] appl,
  output logic [NUM_STREAMS-1:0]            frame_start
);

  localparam logic [VAL_W-1:0] SAT_V = VAL_W'(SAT);

  logic [NUM_STREAMS-1:0][VAL_W-1:0] pend_d, pend_q, appl_q;
  logic [VAL_W-1:0]                  clamp_v;

  assign clamp_v = (wr_val > DATA_W'(SAT)) ? SAT_V : VAL_W'(wr_val);

  always_comb begin
    pend_d = pend_q;
    if (wr_ofs && (wr_idx < SEL_W'(NUM_STREAMS))) pend_d[wr_idx] = clamp_v;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      appl_q <= '0;
    end else begin
      pend_q <= pend_d;
      if (fp_hit) appl_q <= pend_q;
    end
  end

  for (genvar g = 0; g < NUM_STREAMS; g++) begin : g_strobe
    assign frame_start[g] = (CNT_W'(appl_q[g]) == cnt);
  end

  assign pend = pend_q;
  assign appl = appl_q;

endmodule

// File: rtl/frame_offset_cal.sv
module frame_offset_cal
  import frame_offset_cal_pkg::*;
#(
  parameter int NUM_STREAMS = 24,
  parameter int BIT_CYC     = 4,
  parameter int FRAME_CYC   = 128,
  parameter int ADDR_W      = 7,
  parameter int DATA_W      = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   fp_n,
  input  logic [NUM_STREAMS-1:0] stream_in,
  input  logic                   wr_en,
  input  logic [ADDR_W-1:0]      wr_addr,
  input  logic [DATA_W-1:0]      wr_data,
  input  logic [ADDR_W-1:0]      rd_addr,
  output logic [DATA_W-1:0]      rd_data,
  output logic [NUM_STREAMS-1:0] frame_start_out
);

  localparam int SAT   = 8 * BIT_CYC;
  localparam int VAL_W = $clog2(SAT + 1);
  localparam int SEL_W = $clog2(NUM_STREAMS);
  localparam int CNT_W = $clog2(FRAME_CYC);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  logic                              fp_hit;
  logic [CNT_W-1:0]                  frame_cnt;
  logic                              ctrl_wr, ofs_wr;
  logic                              busy;
  logic [SEL_W-1:0]                  sel;
  logic [NUM_STREAMS-1:0][VAL_W-1:0] res_val, pend, appl;
  logic [NUM_STREAMS-1:0]            res_done, res_ovf;

  assign fp_hit  = !fp_n;
  assign ctrl_wr = wr_en && (wr_addr == '0) && wr_data[DATA_W-1];
  assign ofs_wr  = wr_en && (wr_addr[ADDR_W-1 -: 2] == REG_OFS);

  fofc_frame_timer #(.FRAME_CYC(FRAME_CYC)) i_timer (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .fp_hit (fp_hit),
    .cnt    (frame_cnt)
  );

  fofc_measure #(.NUM_STREAMS(NUM_STREAMS), .SAT(SAT)) i_measure (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .start_req (ctrl_wr),
    .start_sel (wr_data[SEL_W-1:0]),
    .fp_hit    (fp_hit),
    .streams   (stream_in),
    .busy      (busy),
    .sel       (sel),
    .res_val   (res_val),
    .res_done  (res_done),
    .res_ovf   (res_ovf)
  );

  fofc_offset_bank #(
    .NUM_STREAMS(NUM_STREAMS), .SAT(SAT), .DATA_W(DATA_W), .CNT_W(CNT_W)
  ) i_offsets (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .wr_ofs      (ofs_wr),
    .wr_idx      (wr_addr[SEL_W-1:0]),
    .wr_val      (wr_data),
    .fp_hit      (fp_hit),
    .cnt         (frame_cnt),
    .pend        (pend),
    .appl        (appl),
    .frame_start (frame_start_out)
  );

  // host read multiplexer
  logic [SEL_W-1:0] rd_idx;
  logic             rd_idx_ok;

  assign rd_idx    = rd_addr[SEL_W-1:0];
  assign rd_idx_ok = (rd_idx < SEL_W'(NUM_STREAMS));

  always_comb begin
    rd_data = '0;
    unique case (rd_addr[ADDR_W-1 -: 2])
      REG_CTRL: begin
        if (rd_addr == '0) begin
          rd_data[DATA_W-1]  = busy;
          rd_data[SEL_W-1:0] = sel;
        end
      end
      REG_RES: begin
        if (rd_idx_ok) begin
          rd_data[VAL_W-1:0] = res_val[rd_idx];
          rd_data[DATA_W-2]  = res_done[rd_idx];
          rd_data[DATA_W-1]  = res_ovf[rd_idx];
        end
      end
      REG_OFS: begin
        if (rd_idx_ok) rd_data[VAL_W-1:0] = pend[rd_idx];
      end
      default: rd_data = '0;
    endcase
  end

endmodule

// File: rtl/frame_offset_cal_chk.sv
module frame_offset_cal_chk #(
  parameter int NUM_STREAMS = 24,
  parameter int SAT         = 32,
  parameter int ADDR_W      = 7,
  parameter int DATA_W      = 8,
  localparam int VAL_W      = $clog2(SAT + 1),
  localparam int SEL_W      = $clog2(NUM_STREAMS)
) (
  input logic                              clk,
  input logic                              rst_n,
  input logic                              fp_n,
  input logic                              wr_en,
  input logic [ADDR_W-1:0]                 wr_addr,
  input logic [DATA_W-1:0]                 wr_data,
  input logic                              busy,
  input logic [SEL_W-1:0]                  sel,
  input logic [NUM_STREAMS-1:0][VAL_W-1:0] res_val,
  input logic [NUM_STREAMS-1:0]            res_done,
  input logic [NUM_STREAMS-1:0]            res_ovf,
  input logic [NUM_STREAMS-1:0][VAL_W-1:0] pend,
  input logic [NUM_STREAMS-1:0][VAL_W-1:0] appl
);

  logic ctrl_start;
  assign ctrl_start = wr_en && (wr_addr == '0) && wr_data[DATA_W-1];

  // R2: an accepted start leaves the target's completion flag clear
  a_r2_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_start && !busy && (wr_data[SEL_W-1:0] < SEL_W'(NUM_STREAMS)))
      |=> (busy && !res_done[sel]));

  // R6: end of a measurement always leaves the completion flag set
  a_r6_done_on_end: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> res_done[sel]);

  // R7: control writes during a measurement do not move the selection
  a_r7_busy_ignore: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && ctrl_start) |=> $stable(sel));

  // R10: offsets in use only change on a reference pulse
  a_r10_apply_on_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    fp_n |=> $stable(appl));

  for (genvar g = 0; g < NUM_STREAMS; g++) begin : g_chk
    // R4: stored value never exceeds the limit
    a_r4_value_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      res_val[g] <= VAL_W'(SAT));
    // R5: an overflow result carries the limit value
    a_r5_ovf_saturated: assert property (@(posedge clk) disable iff (!rst_n)
      res_ovf[g] |-> (res_done[g] && (res_val[g] == VAL_W'(SAT))));
    // R8: pending offsets are clamped
    a_r8_offset_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      pend[g] <= VAL_W'(SAT));
  end

endmodule

bind frame_offset_cal frame_offset_cal_chk #(
  .NUM_STREAMS(NUM_STREAMS), .SAT(SAT), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) i_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .fp_n     (fp_n),
  .wr_en    (wr_en),
  .wr_addr  (wr_addr),
  .wr_data  (wr_data),
  .busy     (busy),
  .sel      (sel),
  .res_val  (res_val),
  .res_done (res_done),
  .res_ovf  (res_ovf),
  .pend     (pend),
  .appl     (appl)
);

// File: tb/test_frame_offset_cal.sv
module test_frame_offset_cal;

  localparam int NS    = 24;
  localparam int FRAME = 128;

  logic          clk;
  logic          rst_n;
  logic          fp_n;
  logic [NS-1:0] stream_in;
  logic          wr_en;
  logic [6:0]    wr_addr;
  logic [7:0]    wr_data;
  logic [6:0]    rd_addr;
  logic [7:0]    rd_data;
  logic [NS-1:0] frame_start_out;

  int checks = 0;
  int errors = 0;

  frame_offset_cal i_frame_offset_cal (
    .clk             (clk),
    .rst_n           (rst_n),
    .fp_n            (fp_n),
    .stream_in       (stream_in),
    .wr_en           (wr_en),
    .wr_addr         (wr_addr),
    .wr_data         (wr_data),
    .rd_addr         (rd_addr),
    .rd_data         (rd_data),
    .frame_start_out (frame_start_out)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // stream, marker delay (255 = none), other stream to toggle (31 = none), expected result
  localparam int CASES [7][4] = '{
    '{ 0,   0, 31, 'h40},
    '{ 5,   3,  6, 'h43},
    '{23,  17,  0, 'h51},
    '{10,  31, 31, 'h5F},
    '{ 7,  32, 31, 'h60},
    '{12,  45, 13, 'h60},
    '{ 3, 255, 31, 'hE0}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [6:0] a, output logic [7:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  task automatic wait_idle();
    logic [7:0] d;
    for (int w = 0; w < 400; w++) begin
      rd(7'h00, d);
      if (!d[7]) break;
      @(negedge clk);
    end
  endtask

  // frame pulse, then watch strobes of streams 2 and 5 over positions 0..40
  task automatic track(input bit do_wr, output int p2, output int c2,
                       output int p5, output int c5);
    p2 = -1; c2 = 0; p5 = -1; c5 = 0;
    @(negedge clk); fp_n = 1'b0;
    @(negedge clk); fp_n = 1'b1;
    if (do_wr) begin wr_en = 1'b1; wr_addr = 7'h42; wr_data = 8'd6; end
    for (int p = 0; p <= 40; p++) begin
      if (p > 0) @(negedge clk);
      if (p == 1) wr_en = 1'b0;
      #1;
      if (frame_start_out[2]) begin if (p2 < 0) p2 = p; c2++; end
      if (frame_start_out[5]) begin if (p5 < 0) p5 = p; c5++; end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] d;
    int p2, c2, p5, c5;
    rst_n = 1'b0; fp_n = 1'b1; stream_in = '1;
    wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    rd(7'h00, d); chk("R1 ctrl", d, 0);
    rd(7'h20, d); chk("R1 result0", d, 0);
    rd(7'h37, d); chk("R1 result23", d, 0);
    rd(7'h45, d); chk("R1 offset5", d, 0);
    #1; chk("R1 strobes", int'(frame_start_out), 0);

    // measurement table: R2 R3 R4 R5 R6 R11
    for (int i = 0; i < 7; i++) begin
      int s, dl, nz, ex;
      s = CASES[i][0]; dl = CASES[i][1]; nz = CASES[i][2]; ex = CASES[i][3];
      wr(7'h00, 8'h80 | 8'(s));
      rd(7'h00, d); chk("R2 busy and select", d, 'h80 | s);
      rd(7'h20 + 7'(s), d); chk("R2 result cleared", d, 0);
      @(negedge clk); fp_n = 1'b0;
      @(negedge clk); fp_n = 1'b1;
      if (nz != 31) stream_in[nz] = 1'b0; // R11 noise on another stream
      if (dl != 255) begin
        repeat (dl) @(negedge clk);
        stream_in[s] = 1'b0;
      end else begin
        repeat (FRAME - 2) @(negedge clk);
        fp_n = 1'b0;
        @(negedge clk); fp_n = 1'b1;
      end
      wait_idle();
      rd(7'h00, d); chk("R6 busy cleared", int'(d[7]), 0);
      rd(7'h20 + 7'(s), d); chk("R3 R4 R5 R11 result", d, ex);
      stream_in = '1;
      repeat (2) @(negedge clk);
    end
    rd(7'h20, d); chk("R6 earlier result kept", d, 'h40);

    // R7: control write while busy is ignored
    wr(7'h00, 8'h84);
    wr(7'h00, 8'h89);
    rd(7'h00, d); chk("R7 write while busy", d, 'h84);
    @(negedge clk); fp_n = 1'b0;
    @(negedge clk); fp_n = 1'b1;
    repeat (2) @(negedge clk);
    stream_in[4] = 1'b0;
    wait_idle();
    rd(7'h24, d); chk("R3 stream4 delay2", d, 'h42);
    stream_in = '1;
    // R7: out-of-range stream number is ignored
    wr(7'h00, 8'h9E);
    rd(7'h00, d); chk("R7 select out of range", int'(d[7]), 0);

    // R8: clamping and read-back
    wr(7'h42, 8'd50);
    rd(7'h42, d); chk("R8 clamp", d, 32);
    wr(7'h42, 8'd3);
    rd(7'h42, d); chk("R8 readback", d, 3);

    // R9 R10: offset applied at pulse; mid-frame write waits
    track(1'b1, p2, c2, p5, c5);
    chk("R10 new offset used at pulse", p2, 3);
    chk("R9 single strobe stream2", c2, 1);
    chk("R9 zero offset stream5", p5, 0);
    chk("R9 single strobe stream5", c5, 1);
    rd(7'h42, d); chk("R8 pending after write", d, 6);
    track(1'b0, p2, c2, p5, c5);
    chk("R10 pending used next frame", p2, 6);
    chk("R9 single strobe next frame", c2, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule